// File: doc/BRIEF.md
# SPI Master Burst Controller

This block is an SPI master that moves one unbroken burst of a programmable number of bits. The burst can be any length from 1 bit up to the limit of the length field. Chip select stays low from the first bit to the last bit, even when the burst crosses 32-bit word boundaries and even when the bit count is not a whole number of bytes. A typical use is an 8-bit address followed by a 32-bit data word, sent as one 40-bit burst. Transmit words come from an external first-word-fall-through FIFO. Received bits are packed into words and pushed into an external receive FIFO.

Software gives a length, a clock divider and a start pulse. The engine loads the first word and keeps only the low (length mod 32) bits of it, or all 32 bits when the length is a multiple of 32. Every later word is a full word. All bits are shifted most significant bit first in SPI mode 0. If the transmit FIFO is empty at a word boundary, the engine holds SCLK low with chip select still asserted and waits for data. It never closes the burst early. After the last bit, chip select is kept high for a guard time of one SCLK period, and then a done pulse is raised.

Top module: `spi_burst_master`

## Requirements
- R1: A burst started with a non-zero `cfgLen` produces exactly `cfgLen` rising SCLK edges. This includes lengths of the form 32n+1 (for example 33, 65 and 97).
- R2: `ssN` goes low before the first rising SCLK edge. It rises only at the falling SCLK edge that ends the last bit, so it is never released between words of a burst.
- R3: The first word popped for a burst supplies its low (`cfgLen` mod 32) bits, or all 32 bits when that value is 0. Each later word supplies 32 bits. Bits are sent on `mosi` most significant first, in FIFO order.
- R4: If `txEmpty` is high when a new word is needed, SCLK stays low, `ssN` stays low and `busy` stays high until a word arrives. The burst then continues with no bit lost.
- R5: SCLK idles low. It has no edge while `ssN` is high, so no stray clock edge appears between bursts.
- R6: Mode 0 is used. `mosi` changes only while SCLK is low, and `miso` is captured at the rising SCLK edge.
- R7: Received bits are grouped in the same way as transmit words. The first receive word holds the first (`cfgLen` mod 32, or 32) bits right-aligned with zeros above. Later words hold 32 bits. The earliest bit is at the highest valid position, and `rxPush` pulses once per word.
- R8: SCLK stays high for exactly `cfgDiv`+1 system clocks. Inside a word, the period is 2×(`cfgDiv`+1) clocks. With a 200 MHz clock, `cfgDiv`=4 gives 20 MHz.
- R9: `busy` goes high the cycle after an accepted start and covers the whole time `ssN` is low. `ssN` then stays high for at least 2×(`cfgDiv`+1) clocks. After that, `done` pulses for one cycle while `busy` falls.
- R10: A start with `cfgLen`=0 is ignored. A start while `busy` is high is ignored, and so is any change to `cfgLen` or `cfgDiv` during a burst.
- R11: `txPop` pulses exactly once per word, only while `txEmpty` is low and `ssN` is low. A burst pops ceil(`cfgLen`/32) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (sampled while idle) |
| cfgLen | input | LEN_W | Burst length in bits |
| cfgDiv | input | DIV_W | SCLK divider; half period is cfgDiv+1 clocks |
| txWord | input | 32 | Head word of the transmit FIFO |
| txEmpty | input | 1 | Transmit FIFO has no word |
| txPop | output | 1 | Take the head word of the transmit FIFO |
| rxWord | output | 32 | Packed receive word |
| rxPush | output | 1 | Write rxWord into the receive FIFO |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Active-low chip select |
| busy | output | 1 | Burst or guard time in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
Two events can land on the same clock edge. One is the falling SCLK edge that finishes a transmit word. The other is the pop of the next word, or, on the last bit, the release of chip select together with the push of the last receive word. Bursts of 33, 65 and 97 bits force a single-bit word right next to full words. A stalled burst forces the boundary to wait on an empty FIFO. Back-to-back bursts put a new start in the same cycle as `done`. A behavioural slave in the bench watches every clock. It collects the bits sent on `mosi` and compares them with the expected bit stream, drives `miso` from a known queue, and flags any edge, chip-select release or phase length that differs from the requirements.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam int unsigned CNT_W = IDX_W + 1;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic             load;
    logic [CNT_W-1:0] loadBits;
    logic             sample;
    logic             shift;
  } burstStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_GUARD
  } burstState_t;
endpackage

// File: rtl/spi_burst_dp.sv
`timescale 1ns/1ps
module spi_burst_dp
  import spi_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic [CNT_W-1:0]  alignAmt;

  // move the valid low bits of a partial word up to the MSB
  assign alignAmt = CNT_W'(WORD_W) - strobe.loadBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= txWord << alignAmt;
        rxShift <= '0;
      end else begin
        if (strobe.shift)  txShift <= {txShift[WORD_W-2:0], 1'b0};
        if (strobe.sample) rxShift <= {rxShift[WORD_W-2:0], miso};
      end
    end
  end

  assign mosi   = txShift[WORD_W-1];
  assign rxWord = rxShift;
endmodule

// File: rtl/spi_burst_ctrl.sv
`timescale 1ns/1ps
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int unsigned LEN_W = 10,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             txEmpty,
  output burstStrobe_t     strobe,
  output logic             txPop,
  output logic             rxPush,
  output logic             sclk,
  output logic             ssN,
  output logic             busy,
  output logic             done
);
  burstState_t      state;
  logic [DIV_W-1:0] divQ;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W:0]   guardCnt;
  logic [LEN_W-1:0] bitsLeft;
  logic [CNT_W-1:0] wordLeft;
  logic [CNT_W-1:0] nextBits;
  logic             phaseEnd;

  // remaining length mod word size gives the partial first word; afterwards it is 0
  assign nextBits = (bitsLeft[IDX_W-1:0] == '0) ? CNT_W'(WORD_W)
                                                : {1'b0, bitsLeft[IDX_W-1:0]};
  assign phaseEnd = (divCnt == divQ);

  always_comb begin
    strobe = '0;
    txPop  = 1'b0;
    rxPush = 1'b0;
    case (state)
      ST_LOAD: if (!txEmpty) begin
        strobe.load     = 1'b1;
        strobe.loadBits = nextBits;
        txPop           = 1'b1;
      end
      ST_LOW:  strobe.sample = phaseEnd;
      ST_HIGH: if (phaseEnd) begin
        strobe.shift = 1'b1;
        rxPush       = (wordLeft == CNT_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divQ     <= '0;
      divCnt   <= '0;
      guardCnt <= '0;
      bitsLeft <= '0;
      wordLeft <= '0;
      sclk     <= 1'b0;
      ssN      <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start && cfgLen != '0) begin
          divQ     <= cfgDiv;
          bitsLeft <= cfgLen;
          ssN      <= 1'b0;
          state    <= ST_LOAD;
        end
        ST_LOAD: if (!txEmpty) begin
          wordLeft <= nextBits;
          divCnt   <= '0;
          state    <= ST_LOW;
        end
        ST_LOW: if (phaseEnd) begin
          divCnt <= '0;
          sclk   <= 1'b1;
          state  <= ST_HIGH;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        ST_HIGH: if (phaseEnd) begin
          divCnt   <= '0;
          sclk     <= 1'b0;
          bitsLeft <= bitsLeft - LEN_W'(1);
          wordLeft <= wordLeft - CNT_W'(1);
          if (bitsLeft == LEN_W'(1)) begin
            ssN      <= 1'b1;
            guardCnt <= '0;
            state    <= ST_GUARD;
          end else if (wordLeft == CNT_W'(1)) begin
            state <= ST_LOAD;
          end else begin
            state <= ST_LOW;
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        ST_GUARD: if (guardCnt == {divQ, 1'b1}) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else begin
          guardCnt <= guardCnt + (DIV_W+1)'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned LEN_W = 10,
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txEmpty,
  output logic              txPop,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxPush,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN,
  output logic              busy,
  output logic              done
);
  burstStrobe_t strobe;

  spi_burst_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgLen(cfgLen), .cfgDiv(cfgDiv),
    .txEmpty(txEmpty), .strobe(strobe), .txPop(txPop), .rxPush(rxPush),
    .sclk(sclk), .ssN(ssN), .busy(busy), .done(done)
  );

  spi_burst_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(txWord), .miso(miso),
    .mosi(mosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spi_burst_checker.sv
`timescale 1ns/1ps
module spi_burst_checker (
  input logic clk,
  input logic rstN,
  input logic txEmpty,
  input logic txPop,
  input logic sclk,
  input logic mosi,
  input logic ssN,
  input logic busy,
  input logic done
);
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sclk);

  p_ss_release_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> $fell(sclk));

  p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_busy_cover_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ssN |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && ssN));

  p_pop_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (!txEmpty && !ssN && !sclk));
endmodule

bind spi_burst_master spi_burst_checker chk_i (
  .clk(clk), .rstN(rstN), .txEmpty(txEmpty), .txPop(txPop), .sclk(sclk),
  .mosi(mosi), .ssN(ssN), .busy(busy), .done(done)
);

// File: tb/spi_burst_master_tb_top.sv
`timescale 1ns/1ps
module spi_burst_master_tb_top;
  localparam int LEN_W = 10;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic [31:0]      txWord;
  logic             txEmpty;
  logic             txPop;
  logic [31:0]      rxWord;
  logic             rxPush;
  logic             sclk, mosi, ssN, busy, done;
  logic             miso = 1'b0;

  spi_burst_master #(.LEN_W(LEN_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgLen(cfgLen), .cfgDiv(cfgDiv),
    .txWord(txWord), .txEmpty(txEmpty), .txPop(txPop), .rxWord(rxWord),
    .rxPush(rxPush), .sclk(sclk), .mosi(mosi), .miso(miso), .ssN(ssN),
    .busy(busy), .done(done)
  );

  // transmit FIFO model
  logic [31:0] txMem [0:255];
  int rdIdx;
  int txAvail = 0;
  assign txWord  = txMem[rdIdx[7:0]];
  assign txEmpty = (rdIdx >= txAvail);
  always @(posedge clk or negedge rstN)
    if (!rstN) rdIdx <= 0;
    else if (txPop) rdIdx <= rdIdx + 1;

  logic [31:0] rxGot[$];
  always @(posedge clk) if (rstN && rxPush) rxGot.push_back(rxWord);

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave and line monitor, sampled away from the active edge
  bit gotBits[$];
  bit misoQ[$];
  int rises = 0, minPeriod = 0, lastRise = 0, cyc = 0, highCnt = 0, ssHighCnt = 0;
  int vioR2 = 0, vioR5 = 0, vioR6 = 0, vioR8 = 0, vioR9 = 0;
  int curDiv = 0, curLen = 0;
  bit prevSclk = 0, prevSs = 1, prevMosi = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (sclk && !prevSclk) begin
        gotBits.push_back(mosi);
        if (rises > 0 && cyc - lastRise < minPeriod) minPeriod = cyc - lastRise;
        lastRise = cyc;
        rises++;
      end
      if (!ssN && (prevSs || (!sclk && prevSclk)))
        if (misoQ.size() > 0) miso = misoQ.pop_front();
      if (ssN && sclk) vioR5++;
      if (sclk && prevSclk && mosi != prevMosi) vioR6++;
      if (sclk) highCnt++;
      else begin
        if (prevSclk && highCnt != curDiv + 1) vioR8++;
        highCnt = 0;
      end
      if (!ssN && !busy) vioR9++;
      if (ssN) ssHighCnt++; else ssHighCnt = 0;
      if (ssN && !prevSs && rises != curLen) vioR2++;
      if (done && (!ssN || busy || ssHighCnt < 2 * (curDiv + 1))) vioR9++;
      prevSclk = sclk; prevSs = ssN; prevMosi = mosi;
    end
  end

  task automatic run_burst(input int len, input int div, input int avail, input bit midStart);
    int nWords = (len + 31) / 32;
    int fb = (len % 32 == 0) ? 32 : len % 32;
    int base = rdIdx;
    logic [31:0] w[$];
    bit expTx[$];
    bit mb[$];
    logic [31:0] expRx[$];
    int mism = 0, k = 0, pos = 0;
    bit sawBusy = 0;
    for (int i = 0; i < nWords; i++) begin
      w.push_back($urandom);
      txMem[(base + i) % 256] = w[i];
    end
    txAvail = base + ((avail < nWords) ? avail : nWords);
    for (int i = 0; i < nWords; i++)
      for (int b = ((i == 0) ? fb : 32) - 1; b >= 0; b--) expTx.push_back(w[i][b]);
    for (int i = 0; i < len; i++) mb.push_back(1'($urandom_range(0, 1)));
    for (int i = 0; i < nWords; i++) begin
      logic [31:0] acc = '0;
      for (int b = 0; b < ((i == 0) ? fb : 32); b++) begin
        acc = {acc[30:0], mb[pos]};
        pos++;
      end
      expRx.push_back(acc);
    end
    misoQ = mb; gotBits.delete(); rxGot.delete();
    rises = 0; minPeriod = 1000000; curDiv = div; curLen = len;
    cfgLen = LEN_W'(len); cfgDiv = DIV_W'(div); start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    if (avail < nWords) begin
      int availBits = fb + 32 * (avail - 1);
      while (!(rises == availBits && !sclk)) @(negedge clk);
      repeat (150) @(negedge clk);
      #1;
      check(rises == availBits && !ssN && !sclk && busy,
            "R4 stall keeps ssN low, sclk low, busy high", rises, availBits);
      txAvail = base + nWords;
    end
    forever begin
      @(negedge clk);
      if (done) break;
      k++;
      if (midStart && k == 20) begin #1 cfgLen = LEN_W'(5); cfgDiv = DIV_W'(0); start = 1'b1; end
      else if (midStart && k == 21) begin #1 start = 1'b0; end
    end
    #1;
    check(rises == len, "R1 rising edge count", rises, len);
    for (int i = 0; i < len; i++)
      if (i >= gotBits.size() || gotBits[i] != expTx[i]) mism++;
    check(mism == 0, "R3 mosi bit stream mismatches", mism, 0);
    mism = 0;
    for (int i = 0; i < nWords; i++)
      if (i >= rxGot.size() || rxGot[i] != expRx[i]) mism++;
    check(mism == 0 && rxGot.size() == nWords, "R7 receive words", rxGot.size(), nWords);
    check(rdIdx - base == nWords, "R11 words popped", rdIdx - base, nWords);
    if (len >= 2)
      check(minPeriod == 2 * (div + 1), "R8 sclk period in clocks", minPeriod, 2 * (div + 1));
    if (midStart) begin
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy || !ssN) sawBusy = 1; end
      #1;
      check(!sawBusy, "R10 start during busy left no second burst", sawBusy, 0);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit sawAct;
    int idx0;
    repeat (3) @(negedge clk);
    check(ssN && !sclk && !busy && !done && !txPop && !rxPush,
          "reset state (R5 R9)", {ssN, sclk, busy, done}, 4'b1000);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    run_burst(40, 4, 99, 0);   // 20 MHz at 200 MHz clock
    run_burst(33, 1, 99, 0);   // 32n+1, n=1
    run_burst(65, 0, 99, 0);   // 32n+1, n=2
    run_burst(1, 2, 99, 0);
    run_burst(32, 3, 99, 0);
    run_burst(72, 1, 1, 0);    // stall after first word
    run_burst(97, 0, 99, 0);
    run_burst(40, 2, 99, 1);   // start ignored while busy
    // R10: zero length is ignored
    idx0 = rdIdx; sawAct = 0;
    cfgLen = '0; cfgDiv = DIV_W'(1); start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy || !ssN || sclk) sawAct = 1; end
    #1;
    check(!sawAct && rdIdx == idx0, "R10 zero-length start ignored", sawAct, 0);
    check(vioR2 == 0, "R2 ssN released early", vioR2, 0);
    check(vioR5 == 0, "R5 sclk activity with ssN high", vioR5, 0);
    check(vioR6 == 0, "R6 mosi changed while sclk high", vioR6, 0);
    check(vioR8 == 0, "R8 sclk high phase length", vioR8, 0);
    check(vioR9 == 0, "R9 busy/done/guard violations", vioR9, 0);
    finish_run();
  end
endmodule